// File: doc/BRIEF.md
# Sliding-Window Match Compressor

This block turns a byte stream into a stream of compression tokens. Bytes enter one per clock through a valid/ready handshake. Each accepted byte is written into a 512-entry history store at a rotating write address. In the same cycle the byte is compared against every stored byte. A vector of live candidates, indexed by the address of the byte each candidate expects next, is narrowed on every step. When no candidate survives, the pending phrase is sent out as one token. A phrase of one byte becomes a literal. A longer phrase becomes a back-reference that tells the decoder to copy a number of bytes from a fixed distance behind the current position.

Tokens leave through a one-deep registered valid/ready output. A flush input pushes out whatever phrase is still pending, for use at the end of a stream. The history store and the match pointer are kept across a flush and are cleared only by reset.

Top module: `slw_compressor`

## Requirements
- R1: After reset, `tok_valid` is 0 and `in_ready` is 1. No history position written before reset can take part in a match.
- R2: While `tok_ready` is 1 and `flush` is 0, `in_ready` stays 1, so the block accepts one byte on every clock.
- R3: A literal token has `tok_ref`=0. It carries the byte in `tok_byte`, and its `tok_dist` and `tok_len` are both 0. A byte that matches nothing in the written history goes out as a literal.
- R4: A back-reference token has `tok_ref`=1 and `tok_byte`=0. `tok_len` holds the copy length L, with 2 ≤ L ≤ 15. `tok_dist` holds D−1, where D (1 to 512) is how many bytes back the copy starts.
- R5: A phrase whose match lasts only one byte goes out as a literal. The shortest reference is 2 bytes.
- R6: On the byte that brings a match to 15 bytes, a reference of length 15 is emitted at once. The byte after it starts a new phrase.
- R7: When several earlier positions match the whole phrase, the reference uses the smallest distance.
- R8: While `flush` is 1, `in_ready` is 0 and no byte is taken. If a phrase is pending and the output slot is free, the phrase is emitted as a token. If nothing is pending, no token is produced.
- R9: While `tok_valid` is 1 and `tok_ready` is 0, the token fields hold steady and `in_ready` is 0. Bytes offered during that time are ignored.
- R10: Distances are counted circularly, so matches stay correct after the write address wraps past the end of the window.
- R11: A token appears on the outputs at the same clock edge that accepts the byte ending its phrase, or at the edge where the flush is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_byte | input | 8 | Input byte |
| flush | input | 1 | Emit the pending phrase; blocks input while high |
| tok_valid | output | 1 | Token present |
| tok_ready | input | 1 | Consumer takes the token |
| tok_ref | output | 1 | 1 = back-reference, 0 = literal |
| tok_byte | output | 8 | Literal byte (0 for references) |
| tok_dist | output | 9 | Distance minus one (0 for literals) |
| tok_len | output | 4 | Copy length (0 for literals) |

## Verification
Each token is due at the clock edge that accepts the byte closing its phrase, or at the edge that takes a flush. A byte that extends a match produces nothing at that edge. The bench drives every byte on a falling edge and samples the outputs 5 ns after the next rising edge. At that point it checks, for each byte, whether a token is present and what its fields are. `in_ready` is combinational, so the bench checks it at the same sample point, before the held or flushed condition is removed.

// File: rtl/slw_pkg.sv
package slw_pkg;
    localparam int BYTE_W      = 8;
    localparam int WIN_DEF     = 512;
    localparam int MAX_LEN_DEF = 15;
    localparam int MIN_LEN_DEF = 2;

    typedef enum logic {
        TK_LIT = 1'b0,
        TK_REF = 1'b1
    } tok_kind_e;
endpackage

// File: rtl/slw_history.sv
module slw_history #(
    parameter int WIN = slw_pkg::WIN_DEF,
    localparam int AW = $clog2(WIN)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [slw_pkg::BYTE_W-1:0] wr_data,
    input  logic [slw_pkg::BYTE_W-1:0] cmp_byte,
    output logic [WIN-1:0]             eq
);
    logic [slw_pkg::BYTE_W-1:0] mem [WIN];
    logic [WIN-1:0]             filled;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        filled <= '0;
        else if (wr_en) filled[wr_addr] <= 1'b1;
    end

    // every slot compared in parallel, before this cycle's write
    for (genvar g = 0; g < WIN; g++) begin : g_cmp
        assign eq[g] = filled[g] && (mem[g] == cmp_byte);
    end
endmodule

// File: rtl/slw_nearest.sv
module slw_nearest #(
    parameter int WIN = slw_pkg::WIN_DEF,
    localparam int AW = $clog2(WIN)
) (
    input  logic [WIN-1:0] hit,
    input  logic [AW-1:0]  pos,
    output logic [AW-1:0]  dist_m1
);
    logic [AW-1:0] lo_pick, hi_pick, pick;
    logic          lo_any;

    // smallest circular distance: highest hit below pos, else highest overall
    always_comb begin
        lo_pick = '0;
        hi_pick = '0;
        lo_any  = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            if (hit[i]) begin
                hi_pick = AW'(i);
                if (AW'(i) < pos) begin
                    lo_pick = AW'(i);
                    lo_any  = 1'b1;
                end
            end
        end
        pick    = lo_any ? lo_pick : hi_pick;
        dist_m1 = pos - pick - AW'(1);
    end
endmodule

// File: rtl/slw_compressor.sv
module slw_compressor #(
    parameter int WIN     = slw_pkg::WIN_DEF,
    parameter int MAX_LEN = slw_pkg::MAX_LEN_DEF,
    parameter int MIN_LEN = slw_pkg::MIN_LEN_DEF,
    localparam int AW = $clog2(WIN),
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [slw_pkg::BYTE_W-1:0] in_byte,
    input  logic                       flush,
    output logic                       tok_valid,
    input  logic                       tok_ready,
    output logic                       tok_ref,
    output logic [slw_pkg::BYTE_W-1:0] tok_byte,
    output logic [AW-1:0]              tok_dist,
    output logic [LW-1:0]              tok_len
);
    import slw_pkg::*;

    logic [AW-1:0]     wptr, n_wptr;
    logic [LW-1:0]     plen, n_plen;
    logic [BYTE_W-1:0] plit, n_plit;
    logic [WIN-1:0]    cand, n_cand;
    logic [AW-1:0]     pdist, n_pdist;

    logic [WIN-1:0]    eq, cont_hit, sel_hit, rot_hit;
    logic [AW-1:0]     near;
    logic              slot_free, take, cont;

    logic              emit;
    tok_kind_e         e_kind;
    logic [BYTE_W-1:0] e_byte;
    logic [AW-1:0]     e_dist;
    logic [LW-1:0]     e_len;

    assign slot_free = !tok_valid || tok_ready;
    assign in_ready  = slot_free && !flush;
    assign take      = in_valid && in_ready;

    slw_history #(.WIN(WIN)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (take),
        .wr_addr  (wptr),
        .wr_data  (in_byte),
        .cmp_byte (in_byte),
        .eq       (eq)
    );

    assign cont_hit = cand & eq;
    assign cont     = (plen != '0) && (|cont_hit);
    assign sel_hit  = cont ? cont_hit : eq;
    assign rot_hit  = {sel_hit[WIN-2:0], sel_hit[WIN-1]};

    slw_nearest #(.WIN(WIN)) u_near (
        .hit     (sel_hit),
        .pos     (wptr),
        .dist_m1 (near)
    );

    always_comb begin
        n_wptr  = wptr;
        n_plen  = plen;
        n_plit  = plit;
        n_cand  = cand;
        n_pdist = pdist;
        emit    = 1'b0;
        e_kind  = TK_LIT;
        e_byte  = '0;
        e_dist  = '0;
        e_len   = '0;
        if (take) begin
            n_wptr = wptr + AW'(1);
            if (cont) begin
                if (plen == LW'(MAX_LEN - 1)) begin
                    emit   = 1'b1;
                    e_kind = TK_REF;
                    e_dist = near;
                    e_len  = LW'(MAX_LEN);
                    n_plen = '0;
                    n_cand = '0;
                end else begin
                    n_plen  = plen + LW'(1);
                    n_cand  = rot_hit;
                    n_pdist = near;
                end
            end else begin
                if (plen != '0) begin
                    emit = 1'b1;
                    if (plen >= LW'(MIN_LEN)) begin
                        e_kind = TK_REF;
                        e_dist = pdist;
                        e_len  = plen;
                    end else begin
                        e_byte = plit;
                    end
                end
                n_plen  = LW'(1);
                n_plit  = in_byte;
                n_cand  = rot_hit;
                n_pdist = near;
            end
        end else if (flush && slot_free && plen != '0) begin
            emit = 1'b1;
            if (plen >= LW'(MIN_LEN)) begin
                e_kind = TK_REF;
                e_dist = pdist;
                e_len  = plen;
            end else begin
                e_byte = plit;
            end
            n_plen = '0;
            n_cand = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            plen  <= '0;
            plit  <= '0;
            cand  <= '0;
            pdist <= '0;
        end else begin
            wptr  <= n_wptr;
            plen  <= n_plen;
            plit  <= n_plit;
            cand  <= n_cand;
            pdist <= n_pdist;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_valid <= 1'b0;
            tok_ref   <= 1'b0;
            tok_byte  <= '0;
            tok_dist  <= '0;
            tok_len   <= '0;
        end else if (emit) begin
            tok_valid <= 1'b1;
            tok_ref   <= (e_kind == TK_REF);
            tok_byte  <= e_byte;
            tok_dist  <= e_dist;
            tok_len   <= e_len;
        end else if (tok_ready) begin
            tok_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/slw_compressor_chk.sv
module slw_compressor_chk #(
    parameter int AW      = 9,
    parameter int LW      = 4,
    parameter int MAX_LEN = 15,
    parameter int MIN_LEN = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          flush,
    input logic          tok_valid,
    input logic          tok_ready,
    input logic          tok_ref,
    input logic [7:0]    tok_byte,
    input logic [AW-1:0] tok_dist,
    input logic [LW-1:0] tok_len
);
    // R1: first cycle out of reset carries no token
    a_r1_clean_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tok_valid);

    a_r3_literal_fields: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_ref) |-> (tok_len == '0 && tok_dist == '0));

    a_r4_ref_fields: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ref) |-> (tok_len >= LW'(MIN_LEN) &&
                                    tok_len <= LW'(MAX_LEN) && tok_byte == '0));

    a_r8_flush_blocks: assert property (@(posedge clk) disable iff (rst)
        flush |-> !in_ready);

    a_r9_hold_token: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_ref) &&
            $stable(tok_byte) && $stable(tok_dist) && $stable(tok_len)));

    a_r9_stall_input: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_ready) |-> !in_ready);
endmodule

bind slw_compressor slw_compressor_chk #(
    .AW(AW), .LW(LW), .MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .flush     (flush),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_ref   (tok_ref),
    .tok_byte  (tok_byte),
    .tok_dist  (tok_dist),
    .tok_len   (tok_len)
);

// File: tb/slw_compressor_test.sv
module slw_compressor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = '0;
    logic       flush = 1'b0;
    logic       tok_valid;
    logic       tok_ready = 1'b1;
    logic       tok_ref;
    logic [7:0] tok_byte;
    logic [8:0] tok_dist;
    logic [3:0] tok_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slw_compressor uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .flush(flush), .tok_valid(tok_valid),
        .tok_ready(tok_ready), .tok_ref(tok_ref), .tok_byte(tok_byte),
        .tok_dist(tok_dist), .tok_len(tok_len)
    );

    // row: byte, flush, exp valid, exp ref, exp byte, exp dist-1, exp len
    function automatic logic [31:0] mk(input logic [7:0] b, input logic fl,
                                       input logic ev, input logic er,
                                       input logic [7:0] eb, input logic [8:0] ed,
                                       input logic [3:0] el);
        return {b, fl, ev, er, eb, ed, el};
    endfunction

    localparam int NROW = 16;
    localparam logic [31:0] TBL [NROW] = '{
        mk(8'h41, 0, 0, 0, 8'h00, 9'd0, 4'd0),   // A
        mk(8'h42, 0, 1, 0, 8'h41, 9'd0, 4'd0),   // B  -> lit A (R3, R1 no stale match)
        mk(8'h41, 0, 1, 0, 8'h42, 9'd0, 4'd0),   // A  -> lit B
        mk(8'h42, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h41, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h42, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h43, 0, 1, 1, 8'h00, 9'd1, 4'd4),   // C  -> ref D=2 L=4 (R4, R11)
        mk(8'h00, 1, 1, 0, 8'h43, 9'd0, 4'd0),   // flush -> lit C (R8)
        mk(8'h41, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h42, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h58, 0, 1, 1, 8'h00, 9'd2, 4'd2),   // X  -> ref D=3 L=2 (R7 nearest)
        mk(8'h00, 1, 1, 0, 8'h58, 9'd0, 4'd0),   // flush -> lit X
        mk(8'h00, 1, 0, 0, 8'h00, 9'd0, 4'd0),   // flush, nothing pending (R8)
        mk(8'h41, 0, 0, 0, 8'h00, 9'd0, 4'd0),
        mk(8'h59, 0, 1, 0, 8'h41, 9'd0, 4'd0),   // Y  -> lit A, 1-byte match (R5)
        mk(8'h00, 1, 1, 0, 8'h59, 9'd0, 4'd0)    // flush -> lit Y
    };

    task automatic check_tok(input string req, input logic ev, input logic er,
                             input logic [7:0] eb, input logic [8:0] ed,
                             input logic [3:0] el);
        logic [22:0] act, exp;
        act = {tok_valid, tok_ref, tok_byte, tok_dist, tok_len};
        exp = {ev, er, eb, ed, el};
        checks++;
        if (!ev) begin
            if (tok_valid !== 1'b0) begin
                errors++;
                $display("FAIL %s token valid=%b expected no token", req, tok_valid);
            end
        end else if (act !== exp) begin
            errors++;
            $display("FAIL %s token actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] b, input logic fl);
        @(negedge clk);
        in_valid = v;
        in_byte  = b;
        flush    = fl;
        @(posedge clk);
        #5;
    endtask

    task automatic release_in();
        in_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        release_in();
        tok_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        #5;
        // R1 reset state
        check_bit("R1 tok_valid after reset", tok_valid, 1'b0);
        check_bit("R1 in_ready after reset", in_ready, 1'b1);

        for (int r = 0; r < NROW; r++) begin
            logic [31:0] w;
            w = TBL[r];
            step(!w[23], w[31:24], w[23]);
            if (w[23]) check_bit("R8 in_ready low during flush", in_ready, 1'b0);
            check_tok("R3/R4/R5/R7/R8 table row", w[22], w[21], w[20:13], w[12:4], w[3:0]);
            release_in();
        end

        // R6: run of equal bytes reaches the length cap
        do_reset();
        for (int p = 0; p < 18; p++) begin
            step(1'b1, 8'h5A, 1'b0);
            if (p == 1)       check_tok("R6 first literal", 1, 0, 8'h5A, 9'd0, 4'd0);
            else if (p == 15) check_tok("R6 capped reference", 1, 1, 8'h00, 9'd0, 4'd15);
            else              check_tok("R6 no token", 0, 0, 8'h00, 9'd0, 4'd0);
            check_bit("R2 in_ready sustained", in_ready, 1'b1);
            release_in();
        end
        step(1'b0, 8'h00, 1'b1);
        check_tok("R6 restart after cap then flush", 1, 1, 8'h00, 9'd0, 4'd2);
        release_in();

        // R10: long run crossing the window wrap several times
        do_reset();
        for (int p = 0; p < 1200; p++) begin
            step(1'b1, 8'h55, 1'b0);
            if (p == 1)
                check_tok("R10 first literal", 1, 0, 8'h55, 9'd0, 4'd0);
            else if (p >= 15 && (p % 15) == 0)
                check_tok("R10 wrapped reference", 1, 1, 8'h00, 9'd0, 4'd15);
            else
                check_tok("R10 no token", 0, 0, 8'h00, 9'd0, 4'd0);
            release_in();
        end

        // R9: output backpressure
        do_reset();
        step(1'b1, 8'h41, 1'b0);
        release_in();
        @(negedge clk);
        tok_ready = 1'b0;
        in_valid  = 1'b1;
        in_byte   = 8'h42;
        @(posedge clk);
        #5;
        release_in();
        check_tok("R9 token loaded", 1, 0, 8'h41, 9'd0, 4'd0);
        check_bit("R9 in_ready low while held", in_ready, 1'b0);
        for (int k = 0; k < 2; k++) begin
            step(1'b1, 8'h51, 1'b0);
            check_tok("R9 token held", 1, 0, 8'h41, 9'd0, 4'd0);
            check_bit("R9 input stalled", in_ready, 1'b0);
            release_in();
        end
        @(negedge clk);
        tok_ready = 1'b1;
        @(posedge clk);
        #5;
        check_tok("R9 token drained", 0, 0, 8'h00, 9'd0, 4'd0);
        step(1'b0, 8'h00, 1'b1);
        check_tok("R9 offered byte ignored, B pending", 1, 0, 8'h42, 9'd0, 4'd0);
        release_in();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule